// File: doc/BRIEF.md
# One-Hot Instruction Length Merger

This block turns partial length information about one instruction into a single one-hot total length between 1 and 11 bytes. Upstream decoders supply a one-hot code for the opcode byte(s), a one-hot code for the extra bytes that follow an addressing byte, and a flag that marks a two-byte (escaped) opcode. The block never adds binary numbers. Each length line is an OR of AND terms, and each term pairs one opcode code with one extra-byte code.

The merge runs in two stages. The first stage combines the two-byte opcode code with its own extra-byte code and gives lengths 3 to 9. The second stage combines that result, gated by the escape flag, with the one-byte path and gives lengths 1 to 11. The frequent two-byte case of 6 bytes with no addressing byte skips the first stage. It feeds the final stage directly, gated only by the escape flag.

Results are captured on an input strobe and held until the next strobe. When an input group is malformed, an input-error flag is raised and no length line is driven. A separate out-of-range flag reports any captured result that does not have exactly one length line. Slow-path handling of such cases is left to the consumer.

Top module: `olen_merge`

## Requirements
- R1: After reset, `len_oh`, `len_bad`, `in_err` and `out_vld` are all zero.
- R2: The escape flag is `op1[10]`. With `op1` one-hot on bits 0 to 5 (direct lengths 1, 2, 3, 4, 5 and 7 bytes) and `ext1` one-hot, the captured `len_oh` has only bit L-1 set, where L is that direct length. `len_oh` bit k means k+1 bytes.
- R3: `op1` bits 6 to 9 mean an addressing byte follows, with base lengths 2, 3, 4 and 6. `ext1` bits 0 to 4 mean 0, 1, 2, 4 and 5 extra bytes. For these codes the captured length is the base plus the extra count.
- R4: With the escape bit set, the length comes from `op2` and `ext2`. In `op2`, bits 0 to 2 are direct 3, 4 and 6 bytes, and bits 3 and 4 are addressed bases 3 and 4, to which the `ext2` extra count is added. The value of `ext1` does not change the result.
- R5: With the escape bit clear, the values of `op2` and `ext2` have no effect on any output.
- R6: `in_err` is captured high when any of these holds: `op1` is not one-hot, `ext1` is not one-hot, or the escape bit is set and `op2` or `ext2` is not one-hot. In that case `len_oh` is captured as zero.
- R7: `len_bad` is captured high exactly when the captured `len_oh` does not have exactly one bit set. It is therefore high whenever `in_err` is high.
- R8: For every well-formed input set, exactly one `len_oh` bit is set and `len_bad` is low.
- R9: Results are captured at the clock edge where `in_vld` is high. `out_vld` is high for the one following cycle. While `in_vld` is low, `len_oh`, `len_bad` and `in_err` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Capture strobe for the current inputs |
| op1 | input | 11 | One-byte opcode length code; bit 10 is the escape flag |
| ext1 | input | 5 | Extra-byte code for one-byte opcodes |
| op2 | input | 5 | Two-byte opcode length code |
| ext2 | input | 5 | Extra-byte code for two-byte opcodes |
| len_oh | output | 11 | One-hot total length; bit k means k+1 bytes |
| len_bad | output | 1 | Captured length is not exactly one line |
| in_err | output | 1 | Captured inputs were malformed |
| out_vld | output | 1 | Result captured on the previous edge |

## Verification
Every result is due exactly one clock edge after the edge that sampled `in_vld` high. The bench drives inputs on a falling edge and raises `in_vld`. It then checks all outputs on the next falling edge, half a period after the capture edge. Hold behaviour is checked over several later falling edges while `in_vld` stays low and the inputs change. This confirms that nothing moves without the strobe.

// File: rtl/olen_merge.sv
module olen_merge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [10:0] op1,
  input  logic [4:0]  ext1,
  input  logic [4:0]  op2,
  input  logic [4:0]  ext2,
  output logic [10:0] len_oh,
  output logic        len_bad,
  output logic        in_err,
  output logic        out_vld
);

  localparam int OP1_W = 11;
  localparam int OP2_W = 5;
  localparam int EXT_W = 5;
  localparam int LEN_W = 11;
  localparam int ESC_BIT = OP1_W - 1;

  logic d1, d2, d3, d4, d5, d7;
  logic a2, a3, a4, a6, esc;
  logic t_d3, t_d4, t_d6, t_a3, t_a4;
  logic x0, x1, x2, x4, x5;
  logic y0, y1, y2, y4, y5;

  assign d1  = op1[0];
  assign d2  = op1[1];
  assign d3  = op1[2];
  assign d4  = op1[3];
  assign d5  = op1[4];
  assign d7  = op1[5];
  assign a2  = op1[6];
  assign a3  = op1[7];
  assign a4  = op1[8];
  assign a6  = op1[9];
  assign esc = op1[ESC_BIT];

  assign t_d3 = op2[0];
  assign t_d4 = op2[1];
  assign t_d6 = op2[2];
  assign t_a3 = op2[3];
  assign t_a4 = op2[4];

  assign x0 = ext1[0];
  assign x1 = ext1[1];
  assign x2 = ext1[2];
  assign x4 = ext1[3];
  assign x5 = ext1[4];

  assign y0 = ext2[0];
  assign y1 = ext2[1];
  assign y2 = ext2[2];
  assign y4 = ext2[3];
  assign y5 = ext2[4];

  // first stage: escaped opcode with its own extra bytes, lengths 3..9
  logic s3, s4, s5, s6, s7, s8, s9;

  assign s3 = (t_a3 & y0) | t_d3;
  assign s4 = (t_a3 & y1) | (t_a4 & y0) | t_d4;
  assign s5 = (t_a3 & y2) | (t_a4 & y1);
  assign s6 = (t_a4 & y2);
  assign s7 = (t_a3 & y4);
  assign s8 = (t_a3 & y5) | (t_a4 & y4);
  assign s9 = (t_a4 & y5);

  // final stage: one-byte path merged with the gated first stage
  logic [LEN_W-1:0] raw;

  assign raw[0]  = d1;
  assign raw[1]  = (a2 & x0) | d2;
  assign raw[2]  = (a2 & x1) | (a3 & x0) | d3 | (esc & s3);
  assign raw[3]  = (a2 & x2) | (a3 & x1) | (a4 & x0) | d4 | (esc & s4);
  assign raw[4]  = (a3 & x2) | (a4 & x1) | d5 | (esc & s5);
  assign raw[5]  = (a2 & x4) | (a4 & x2) | (a6 & x0) | (esc & t_d6) | (esc & s6);
  assign raw[6]  = (a2 & x5) | (a3 & x4) | (a6 & x1) | d7 | (esc & s7);
  assign raw[7]  = (a3 & x5) | (a4 & x4) | (a6 & x2) | (esc & s8);
  assign raw[8]  = (a4 & x5) | (esc & s9);
  assign raw[9]  = (a6 & x4);
  assign raw[10] = (a6 & x5);

  logic op1_ok, ext1_ok, op2_ok, ext2_ok, err_n;
  logic [LEN_W-1:0] len_n;

  assign op1_ok  = $onehot(op1);
  assign ext1_ok = $onehot(ext1);
  assign op2_ok  = $onehot(op2);
  assign ext2_ok = $onehot(ext2);
  assign err_n   = !op1_ok || !ext1_ok || (esc && (!op2_ok || !ext2_ok));
  assign len_n   = err_n ? '0 : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_oh  <= '0;
      len_bad <= 1'b0;
      in_err  <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        len_oh  <= len_n;
        in_err  <= err_n;
        len_bad <= ($countones(len_n) != 1);
      end
    end
  end

  // R8
  len_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(len_oh));

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_err |-> (len_oh == '0));

  // R7
  bad_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_err |-> len_bad);

  // R8
  good_not_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !in_err) |-> !len_bad);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vld && $past(rst_n)) |=> ($stable(len_oh) && $stable(in_err) && $stable(len_bad)));

  // R5
  esc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !esc && op1_ok && ext1_ok) |=> !in_err);

endmodule

// File: tb/olen_merge_test.sv
`timescale 1ns/1ps
module olen_merge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [10:0] op1 = '0;
  logic [4:0]  ext1 = '0;
  logic [4:0]  op2 = '0;
  logic [4:0]  ext2 = '0;
  logic [10:0] len_oh;
  logic        len_bad, in_err, out_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  olen_merge uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .op1(op1), .ext1(ext1), .op2(op2), .ext2(ext2),
    .len_oh(len_oh), .len_bad(len_bad), .in_err(in_err), .out_vld(out_vld)
  );

  function automatic int ext_val(input logic [4:0] e);
    int v = 0;
    for (int i = 0; i < 5; i++) if (e[i]) v = (i < 3) ? i : i + 1;
    return v;
  endfunction

  function automatic int exp_len(input logic [10:0] o1, input logic [4:0] e1,
                                 input logic [4:0] o2, input logic [4:0] e2);
    int direct1 [6] = '{1, 2, 3, 4, 5, 7};
    int based1  [4] = '{2, 3, 4, 6};
    int direct2 [3] = '{3, 4, 6};
    if ($countones(o1) != 1 || $countones(e1) != 1) return 0;
    if (o1[10]) begin
      if ($countones(o2) != 1 || $countones(e2) != 1) return 0;
      for (int i = 0; i < 3; i++) if (o2[i]) return direct2[i];
      return (o2[3] ? 3 : 4) + ext_val(e2);
    end
    for (int i = 0; i < 6; i++) if (o1[i]) return direct1[i];
    for (int i = 0; i < 4; i++) if (o1[6+i]) return based1[i] + ext_val(e1);
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [10:0] v);
    int r = 0;
    if ($countones(v) != 1) return 0;
    for (int i = 0; i < 11; i++) if (v[i]) r = i + 1;
    return r;
  endfunction

  task automatic apply(input string req, input logic [10:0] o1, input logic [4:0] e1,
                       input logic [4:0] o2, input logic [4:0] e2);
    int exp;
    @(negedge clk);
    op1 = o1; ext1 = e1; op2 = o2; ext2 = e2; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    exp = exp_len(o1, e1, o2, e2);
    check(req, len_of(len_oh), exp);
    check({req, " raw"}, int'(len_oh), (exp == 0) ? 0 : (1 << (exp - 1)));
    check({req, " err R6"}, int'(in_err), (exp == 0) ? 1 : 0);
    check({req, " bad R7"}, int'(len_bad), (exp == 0) ? 1 : 0);
    check({req, " vld R9"}, int'(out_vld), 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [10:0] held;
    repeat (3) @(negedge clk);
    // R1
    check("R1 len", int'(len_oh), 0);
    check("R1 flags", int'({len_bad, in_err, out_vld}), 0);
    rst_n = 1'b1;

    // R2 R3 R8: one-byte sweep
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 5; j++)
        apply(i < 6 ? "R2" : "R3", 11'(1) << i, 5'(1) << j, 5'b00000, 5'b00000);

    // R4 R8: escaped sweep, ext1 varied to show no effect
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        apply("R4", 11'h400, 5'(1) << ((i + j) % 5), 5'(1) << i, 5'(1) << j);

    // R5: garbage on the two-byte inputs without escape
    apply("R5", 11'h040, 5'b00010, 5'b11111, 5'b00000);
    apply("R5", 11'h008, 5'b00001, 5'b00000, 5'b10101);
    apply("R5", 11'h200, 5'b10000, 5'b01100, 5'b11000);

    // R6 R7: malformed groups
    apply("R6", 11'h000, 5'b00001, 5'b00001, 5'b00001);
    apply("R6", 11'h0C0, 5'b00001, 5'b00001, 5'b00001);
    apply("R6", 11'h002, 5'b00000, 5'b00001, 5'b00001);
    apply("R6", 11'h100, 5'b00110, 5'b00001, 5'b00001);
    apply("R6", 11'h400, 5'b00001, 5'b00000, 5'b00001);
    apply("R6", 11'h400, 5'b00001, 5'b01000, 5'b00011);
    apply("R6", 11'h401, 5'b00001, 5'b00001, 5'b00001);

    // R9: hold while the strobe is low
    apply("R9", 11'h200, 5'b10000, 5'b00000, 5'b00000);
    held = len_oh;
    @(negedge clk);
    op1 = 11'h001; ext1 = 5'b00001;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 hold", int'(len_oh), int'(held));
      check("R9 vld low", int'(out_vld), 0);
      check("R9 err hold", int'(in_err), 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule